// File: doc/BRIEF.md
# Bundle Issue Buffer

This block sits between instruction fetch and the execution units of a statically scheduled wide-issue core. Fetch delivers 128-bit bundles, up to two per cycle, into an eight-entry in-order queue. Each bundle carries a 5-bit template and three 41-bit operations. The template tells which kind of execution unit each operation needs and where the instruction groups end.

Every cycle the block takes operations from the oldest bundle, and when that bundle finishes, from the one after it. It stops taking operations at a group end. It also stops at the first operation for which no unit of the needed kind is left this cycle. A bundle that is only partly sent stays at the front of the queue. Its remaining operations go out in slot order in later cycles. A bundle whose template is not one of the defined codes is thrown away and reported. Six registered output lanes carry valid, assigned unit and operation. Lanes 0 to 2 belong to the bundle at the front. Lanes 3 to 4 and 5 belong to the bundle after it.

Top module: `vliw_issue_buf`

## Requirements
- R1: After reset the queue is empty, every lane is invalid, `out_illegal` is low and `in_ready` is high.
- R2: In a bundle, bits [4:0] are the template, slot 0 is bits [45:5], slot 1 is bits [86:46] and slot 2 is bits [127:87]. Output lane k carries slot k mod 3 of the first issuing bundle (k<3) or of the second (k>=3) on `out_op[41k+40:41k]`.
- R3: Templates 0 to 3 decode to slot kinds M,I,I. Templates 4 and 5 decode to M,L,X. Templates 8 and 9 decode to M,M,I. `out_unit[2k+1:2k]` gives the assigned unit for lane k: M=0, I=1, B=2, F=3.
- R4: An odd template ends a group after slot 2. Templates 2 and 3 also end a group after slot 1. No operation after a group end is issued in the same cycle as the operations before it.
- R5: At most 2 M, 2 I, 3 B and 2 F units are handed out per cycle. An L/X pair issues as one operation on one unit. That unit is I if one is left and B otherwise, and both lanes of the pair report it.
- R6: Issue stops at the first operation whose unit kind is used up. That operation and the ones after it issue in later cycles in slot order, and their bundle stays at the front until all three slots have gone.
- R7: At most two bundles issue per cycle, in arrival order. The second bundle starts only when the first finishes in that cycle with no group end after its slot 2.
- R8: A template other than 0-5, 8 or 9 is illegal. At the front of the queue such a bundle is dropped. One cycle later `out_illegal` is high for one cycle with no lane valid. An illegal bundle is never issued as the second bundle of a cycle.
- R9: `in_ready` is high exactly when at least 2 of the 8 entries are free. When ready, `in_valid[0]` enqueues `in_bundle0` ahead of `in_valid[1]` with `in_bundle1`. When not ready, both inputs are ignored.
- R10: `flush` empties the queue and drops any bundle offered in the same cycle. All lanes and `out_illegal` are low in the following cycle.
- R11: A bundle enqueued at clock edge n first appears on the lanes after edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the queue |
| in_valid | input | 2 | Bundle offered on in_bundle0 / in_bundle1 |
| in_bundle0 | input | 128 | Older incoming bundle |
| in_bundle1 | input | 128 | Younger incoming bundle |
| in_ready | output | 1 | At least two entries free |
| out_valid | output | 6 | Per-lane issue valid |
| out_unit | output | 12 | Per-lane assigned unit, 2 bits per lane |
| out_op | output | 246 | Per-lane operation, 41 bits per lane |
| out_illegal | output | 1 | An illegal bundle was dropped |

## Verification
The hardest case to reach from the ports combines three things. The second bundle of a cycle is cut short by the unit budget. It then resumes from a middle slot as the new front bundle, while the queue is full and fetch is being held off. The bench fills the queue with templates that end groups mid-bundle, so the queue drains more slowly than two bundles per cycle. It then mixes in pairs of I-heavy and L/X templates, so both the fall-back to B units and the partial second bundle occur while `in_ready` is low. Directed sequences pin these cases with literal lane patterns. Seeded random traffic with occasional illegal templates and flushes is compared against a bench-side queue model.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;
  localparam int BUNDLE_W = 128;
  localparam int TMPL_W   = 5;
  localparam int OP_W     = 41;
  localparam int SLOTS    = 3;
  localparam int LANES    = 2 * SLOTS;

  typedef enum logic [1:0] {U_M = 2'd0, U_I = 2'd1, U_B = 2'd2, U_F = 2'd3} unit_e;
  typedef enum logic [2:0] {K_M, K_I, K_B, K_F, K_L, K_X} kind_e;

  typedef struct packed {
    logic                  legal;
    logic [SLOTS-1:0]      stop;   // group ends after slot s
    logic [SLOTS-1:0][2:0] kind;
  } tdec_t;

  function automatic logic [OP_W-1:0] slot_op(input logic [BUNDLE_W-1:0] b, input int s);
    return b[TMPL_W + OP_W*s +: OP_W];
  endfunction
endpackage

// File: rtl/vliw_tmpl_decode.sv
module vliw_tmpl_decode
  import vliw_issue_pkg::*;
(
  input  logic [TMPL_W-1:0] tmpl,
  output tdec_t             dec
);
  always_comb begin
    dec = '0;
    dec.legal = 1'b1;
    case (tmpl)
      5'd0, 5'd1, 5'd2, 5'd3: begin dec.kind[0] = K_M; dec.kind[1] = K_I; dec.kind[2] = K_I; end
      5'd4, 5'd5:             begin dec.kind[0] = K_M; dec.kind[1] = K_L; dec.kind[2] = K_X; end
      5'd8, 5'd9:             begin dec.kind[0] = K_M; dec.kind[1] = K_M; dec.kind[2] = K_I; end
      default:                dec.legal = 1'b0;
    endcase
    dec.stop[2] = dec.legal & tmpl[0];
    dec.stop[1] = (tmpl == 5'd2) || (tmpl == 5'd3);
  end
endmodule

// File: rtl/vliw_bundle_queue.sv
module vliw_bundle_queue #(
  parameter int DEPTH = 8,   // power of two
  parameter int W     = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [1:0]    wr_en,
  input  logic [W-1:0]  wr_d0,
  input  logic [W-1:0]  wr_d1,
  input  logic [1:0]    pop,
  output logic [W-1:0]  rd_d0,
  output logic [W-1:0]  rd_d1,
  output logic [CW-1:0] count,
  output logic          ready
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en[0]) mem[wr_ptr] <= wr_d0;
    if (wr_en[1]) mem[wr_ptr + AW'(wr_en[0])] <= wr_d1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(wr_en[0]) + AW'(wr_en[1]);
      rd_ptr <= rd_ptr + AW'(pop);
      count  <= count + CW'(wr_en[0]) + CW'(wr_en[1]) - CW'(pop);
    end
  end

  assign rd_d0 = mem[rd_ptr];
  assign rd_d1 = mem[rd_ptr + AW'(1)];
  assign ready = (count <= CW'(DEPTH - 2));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH));
  a_r9_pop_bound:   assert property (@(posedge clk) disable iff (rst) CW'(pop) <= count);
endmodule

// File: rtl/vliw_issue_pick.sv
module vliw_issue_pick
  import vliw_issue_pkg::*;
#(
  parameter int M_UNITS = 2,
  parameter int I_UNITS = 2,
  parameter int B_UNITS = 3,
  parameter int F_UNITS = 2,
  parameter int CW      = 4
) (
  input  logic [BUNDLE_W-1:0]      bnd [2],
  input  tdec_t                    dec [2],
  input  logic [CW-1:0]            count,
  input  logic [SLOTS-1:0]         head_mask,
  output logic [LANES-1:0]         lane_v,
  output logic [LANES-1:0][1:0]    lane_u,
  output logic [LANES-1:0][OP_W-1:0] lane_op,
  output logic [1:0]               pop,
  output logic [SLOTS-1:0]         mask_nxt,
  output logic                     drop
);
  int m_left, i_left, b_left, f_left, last;
  logic go, ok;
  logic [SLOTS-1:0] done;
  unit_e u;

  always_comb begin
    m_left = M_UNITS; i_left = I_UNITS; b_left = B_UNITS; f_left = F_UNITS;
    lane_v = '0; lane_u = '0; pop = '0; mask_nxt = head_mask; drop = 1'b0;
    go = (count != '0); ok = 1'b0; u = U_M; last = 0; done = '0;
    for (int bb = 0; bb < 2; bb++)
      for (int s = 0; s < SLOTS; s++)
        lane_op[bb*SLOTS+s] = slot_op(bnd[bb], s);
    if (go && !dec[0].legal) begin
      drop = 1'b1; pop = 2'd1; mask_nxt = '0; go = 1'b0;
    end
    for (int bb = 0; bb < 2; bb++) begin
      done = (bb == 0) ? head_mask : '0;
      if (go && (bb == 0 || (count > CW'(1) && dec[1].legal))) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (go && !done[s]) begin
            ok = 1'b0; u = U_M; last = s;
            case (dec[bb].kind[s])
              K_M: if (m_left > 0) begin m_left--; ok = 1'b1; u = U_M; end
              K_I: if (i_left > 0) begin i_left--; ok = 1'b1; u = U_I; end
              K_B: if (b_left > 0) begin b_left--; ok = 1'b1; u = U_B; end
              K_F: if (f_left > 0) begin f_left--; ok = 1'b1; u = U_F; end
              K_L: begin
                last = (s < SLOTS-1) ? s + 1 : s;
                if (i_left > 0) begin i_left--; ok = 1'b1; u = U_I; end
                else if (b_left > 0) begin b_left--; ok = 1'b1; u = U_B; end
              end
              default: ok = 1'b0;
            endcase
            if (ok) begin
              lane_v[bb*SLOTS+s] = 1'b1;    lane_u[bb*SLOTS+s] = u;    done[s] = 1'b1;
              lane_v[bb*SLOTS+last] = 1'b1; lane_u[bb*SLOTS+last] = u; done[last] = 1'b1;
              if (dec[bb].stop[last]) go = 1'b0;
            end else begin
              go = 1'b0;
            end
          end
        end
        if (&done) begin
          pop = pop + 2'd1;
          mask_nxt = '0;
        end else begin
          mask_nxt = done;
        end
      end
    end
  end
endmodule

// File: rtl/vliw_issue_buf.sv
module vliw_issue_buf
  import vliw_issue_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int M_UNITS = 2,
  parameter int I_UNITS = 2,
  parameter int B_UNITS = 3,
  parameter int F_UNITS = 2,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic [1:0]            in_valid,
  input  logic [BUNDLE_W-1:0]   in_bundle0,
  input  logic [BUNDLE_W-1:0]   in_bundle1,
  output logic                  in_ready,
  output logic [LANES-1:0]      out_valid,
  output logic [2*LANES-1:0]    out_unit,
  output logic [OP_W*LANES-1:0] out_op,
  output logic                  out_illegal
);
  logic [BUNDLE_W-1:0] bnd [2];
  tdec_t               dec [2];
  logic [CW-1:0]       count;
  logic [1:0]          wr_en, pop;
  logic [SLOTS-1:0]    head_mask, mask_nxt;
  logic [LANES-1:0]    lane_v;
  logic [LANES-1:0][1:0]      lane_u, unit_q;
  logic [LANES-1:0][OP_W-1:0] lane_op, op_q;
  logic                drop;

  assign wr_en = in_valid & {2{in_ready & ~flush}};

  vliw_bundle_queue #(.DEPTH(DEPTH), .W(BUNDLE_W)) u_queue (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en),
    .wr_d0(in_bundle0), .wr_d1(in_bundle1), .pop(flush ? 2'd0 : pop),
    .rd_d0(bnd[0]), .rd_d1(bnd[1]), .count(count), .ready(in_ready)
  );

  for (genvar g = 0; g < 2; g++) begin : g_dec
    vliw_tmpl_decode u_dec (.tmpl(bnd[g][TMPL_W-1:0]), .dec(dec[g]));
  end

  vliw_issue_pick #(
    .M_UNITS(M_UNITS), .I_UNITS(I_UNITS), .B_UNITS(B_UNITS), .F_UNITS(F_UNITS), .CW(CW)
  ) u_pick (
    .bnd(bnd), .dec(dec), .count(count), .head_mask(head_mask),
    .lane_v(lane_v), .lane_u(lane_u), .lane_op(lane_op),
    .pop(pop), .mask_nxt(mask_nxt), .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid   <= '0;
      out_illegal <= 1'b0;
      head_mask   <= '0;
    end else begin
      out_valid   <= lane_v;
      out_illegal <= drop;
      head_mask   <= mask_nxt;
    end
  end

  always_ff @(posedge clk) begin
    unit_q <= lane_u;
    op_q   <= lane_op;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign out_unit[2*k +: 2]     = unit_q[k];
    assign out_op[OP_W*k +: OP_W] = op_q[k];
  end

  // assertion-only view: lanes holding an M unit
  logic [LANES-1:0] lane_is_m;
  for (genvar k = 0; k < LANES; k++) begin : g_chk
    assign lane_is_m[k] = out_valid[k] && (unit_q[k] == U_M);
  end

  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_valid == '0));
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (out_valid == '0) && !out_illegal);
  a_r7_second_after_head: assert property (@(posedge clk) disable iff (rst)
    (|out_valid[LANES-1:SLOTS]) |-> out_valid[SLOTS-1]);
  a_r6_second_prefix: assert property (@(posedge clk) disable iff (rst)
    !(out_valid[4] && !out_valid[3]) && !(out_valid[5] && !out_valid[4]));
  a_r5_m_budget: assert property (@(posedge clk) disable iff (rst)
    $countones(lane_is_m) <= M_UNITS);
  a_r11_empty_silent: assert property (@(posedge clk) disable iff (rst || flush)
    (count == '0) |=> (out_valid == '0));
endmodule

// File: tb/sim_vliw_issue_buf.sv
`timescale 1ns/1ps
module sim_vliw_issue_buf;
  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic [1:0] in_valid = '0;
  logic [127:0] in_bundle0 = '0, in_bundle1 = '0;
  logic in_ready, out_illegal;
  logic [5:0] out_valid;
  logic [11:0] out_unit;
  logic [245:0] out_op;

  vliw_issue_buf u0 (.clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_bundle0(in_bundle0), .in_bundle1(in_bundle1), .in_ready(in_ready),
    .out_valid(out_valid), .out_unit(out_unit), .out_op(out_op), .out_illegal(out_illegal));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  logic [127:0] mq [8];
  int mcnt = 0;
  logic [2:0] mmask = '0;
  logic [5:0] ev;
  logic [1:0] eu [6];
  logic [40:0] eo [6];
  logic eill;

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  // kind codes: 0=M 1=I 2=L 3=X, -1 illegal template
  function automatic int kind_of(input logic [4:0] t, input int s);
    case (t)
      5'd0, 5'd1, 5'd2, 5'd3: return (s == 0) ? 0 : 1;
      5'd4, 5'd5:             return (s == 0) ? 0 : ((s == 1) ? 2 : 3);
      5'd8, 5'd9:             return (s == 2) ? 1 : 0;
      default:                return -1;
    endcase
  endfunction

  function automatic bit ends_group(input logic [4:0] t, input int s);
    return (s == 2 && t[0]) || (s == 1 && (t == 5'd2 || t == 5'd3));
  endfunction

  function automatic logic [127:0] mk(input logic [4:0] t, input logic [40:0] base);
    return {base + 41'd2, base + 41'd1, base, t};
  endfunction

  task automatic model_step(input bit fl, input logic [1:0] v,
                            input logic [127:0] d0, input logic [127:0] d1, input bit rdy);
    int m_av, i_av, b_av, popn, kd, u, s;
    bit go;
    logic [2:0] dn;
    logic [4:0] t;
    ev = '0; eill = 1'b0; popn = 0; m_av = 2; i_av = 2; b_av = 3;
    for (int k = 0; k < 6; k++) begin eu[k] = '0; eo[k] = '0; end
    if (fl) begin mcnt = 0; mmask = '0; return; end
    go = (mcnt > 0);
    if (go && kind_of(mq[0][4:0], 0) < 0) begin eill = 1'b1; popn = 1; go = 0; mmask = '0; end
    for (int bb = 0; bb < 2; bb++) begin
      if (go && !(bb == 1 && (mcnt < 2 || kind_of(mq[1][4:0], 0) < 0))) begin
        t = mq[bb][4:0];
        dn = (bb == 0) ? mmask : 3'b000;
        s = 0;
        while (s < 3 && go) begin
          if (!dn[s]) begin
            kd = kind_of(t, s);
            u = -1;
            if (kd == 0 && m_av > 0) begin m_av--; u = 0; end
            else if (kd == 1 && i_av > 0) begin i_av--; u = 1; end
            else if (kd == 2 && i_av > 0) begin i_av--; u = 1; end
            else if (kd == 2 && b_av > 0) begin b_av--; u = 2; end
            if (u < 0) go = 0;
            else begin
              ev[bb*3+s] = 1'b1; eu[bb*3+s] = 2'(u); eo[bb*3+s] = mq[bb][5+41*s +: 41]; dn[s] = 1'b1;
              if (kd == 2) begin
                s++;
                ev[bb*3+s] = 1'b1; eu[bb*3+s] = 2'(u); eo[bb*3+s] = mq[bb][5+41*s +: 41]; dn[s] = 1'b1;
              end
              if (ends_group(t, s)) go = 0;
            end
          end
          s++;
        end
        if (dn == 3'b111) begin popn++; mmask = '0; end
        else mmask = dn;
      end
    end
    for (int k = 0; k < 8; k++) if (k + popn < 8) mq[k] = mq[k + popn];
    mcnt -= popn;
    if (rdy) begin
      if (v[0]) begin mq[mcnt] = d0; mcnt++; end
      if (v[1]) begin mq[mcnt] = d1; mcnt++; end
    end
  endtask

  task automatic cyc(input bit fl, input logic [1:0] v, input logic [127:0] d0, input logic [127:0] d1);
    bit rdy;
    @(negedge clk);
    flush = fl; in_valid = v; in_bundle0 = d0; in_bundle1 = d1;
    #1;
    rdy = (mcnt <= 6);
    chk(in_ready == rdy, "R9 in_ready", 64'(in_ready), 64'(rdy));
    model_step(fl, v, d0, d1, rdy);
    @(posedge clk);
    #1;
    chk(out_valid == ev, "R7 lane valid pattern", 64'(out_valid), 64'(ev));
    chk(out_illegal == eill, "R8 illegal flag", 64'(out_illegal), 64'(eill));
    for (int k = 0; k < 6; k++) if (ev[k]) begin
      chk(out_unit[2*k +: 2] == eu[k], "R5 lane unit", 64'(out_unit[2*k +: 2]), 64'(eu[k]));
      chk(out_op[41*k +: 41] == eo[k], "R2 lane op", 64'(out_op[41*k +: 41]), 64'(eo[k]));
    end
  endtask

  task automatic idle();
    cyc(1'b0, 2'b00, '0, '0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [4:0] legal_t [8];
    logic [4:0] bad_t [4];
    int unsigned seed_v;
    legal_t = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd8, 5'd9};
    bad_t   = '{5'd6, 5'd7, 5'd12, 5'd31};
    seed_v = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk(out_valid == 6'b0, "R1 lanes idle", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1 ready", 64'(in_ready), 64'd1);
    chk(out_illegal == 1'b0, "R1 illegal low", 64'(out_illegal), 64'd0);

    // R11 latency, R3 decode of M,I,I
    cyc(1'b0, 2'b01, mk(5'd0, 41'h100), '0);
    chk(out_valid == 6'b0, "R11 not before edge n+1", 64'(out_valid), 64'd0);
    idle();
    chk(out_valid == 6'b000111, "R11 issued after edge n+1", 64'(out_valid), 64'h07);
    chk(out_unit[5:0] == 6'b010100, "R3 units M,I,I", 64'(out_unit[5:0]), 64'h14);
    chk(out_op[81:41] == 41'h101, "R2 slot 1 op", 64'(out_op[81:41]), 64'h101);

    // R5/R6 I budget cuts the second bundle
    cyc(1'b0, 2'b11, mk(5'd0, 41'h200), mk(5'd0, 41'h300));
    idle();
    chk(out_valid == 6'b001111, "R5 I budget limits second bundle", 64'(out_valid), 64'h0f);
    idle();
    chk(out_valid == 6'b000110, "R6 remainder resumes in slot order", 64'(out_valid), 64'h06);

    // R5 L/X pair falls back to a B unit
    cyc(1'b0, 2'b11, mk(5'd0, 41'h400), mk(5'd4, 41'h500));
    idle();
    chk(out_valid == 6'b111111, "R5 full two-bundle issue", 64'(out_valid), 64'h3f);
    chk(out_unit[11:6] == 6'b101000, "R5 L/X on B unit", 64'(out_unit[11:6]), 64'h28);

    // R4 mid-bundle group end, R7 second bundle after resumed head
    cyc(1'b0, 2'b11, mk(5'd2, 41'h600), mk(5'd0, 41'h700));
    idle();
    chk(out_valid == 6'b000011, "R4 stop after slot 1", 64'(out_valid), 64'h03);
    idle();
    chk(out_valid == 6'b011100, "R7 second bundle after resumed head", 64'(out_valid), 64'h1c);
    idle();
    chk(out_valid == 6'b000100, "R6 last slot of new head", 64'(out_valid), 64'h04);

    // R4 odd template ends group at bundle boundary
    cyc(1'b0, 2'b11, mk(5'd1, 41'h800), mk(5'd0, 41'h900));
    idle();
    chk(out_valid == 6'b000111, "R4 odd template blocks second bundle", 64'(out_valid), 64'h07);
    idle();
    chk(out_op[40:0] == 41'h900, "R7 arrival order kept", 64'(out_op[40:0]), 64'h900);

    // R8 illegal head, then illegal as second bundle
    cyc(1'b0, 2'b11, mk(5'd6, 41'hA00), mk(5'd0, 41'hB00));
    idle();
    chk(out_illegal == 1'b1 && out_valid == 6'b0, "R8 illegal head dropped", {out_illegal, out_valid}, 64'h40);
    idle();
    chk(out_valid == 6'b000111, "R8 next bundle issues", 64'(out_valid), 64'h07);
    cyc(1'b0, 2'b11, mk(5'd0, 41'hC00), mk(5'd7, 41'hD00));
    idle();
    chk(out_valid == 6'b000111 && !out_illegal, "R8 illegal not second", {out_illegal, out_valid}, 64'h07);
    idle();
    chk(out_illegal == 1'b1, "R8 illegal reported at head", 64'(out_illegal), 64'd1);

    // R9 back-pressure with stop-heavy templates, R10 flush
    for (int k = 0; k < 4; k++) cyc(1'b0, 2'b11, mk(5'd3, 41'(k*16)), mk(5'd3, 41'(k*16+8)));
    chk(in_ready == 1'b0, "R9 ready low with 7 held", 64'(in_ready), 64'd0);
    cyc(1'b0, 2'b11, mk(5'd0, 41'hE00), mk(5'd0, 41'hF00));
    cyc(1'b1, 2'b11, mk(5'd0, 41'h1E00), mk(5'd0, 41'h1F00));
    chk(out_valid == 6'b0, "R10 lanes clear after flush", 64'(out_valid), 64'd0);
    idle();
    chk(out_valid == 6'b0 && in_ready, "R10 queue empty after flush", {in_ready, out_valid}, 64'h40);

    // seeded random traffic checked against the model
    for (int n = 0; n < 4000; n++) begin
      int r0, r1;
      logic [4:0] t0, t1;
      r0 = int'($urandom % 20); r1 = int'($urandom % 20);
      t0 = (r0 < 18) ? legal_t[r0 % 8] : bad_t[r0 % 4];
      t1 = (r1 < 18) ? legal_t[r1 % 8] : bad_t[r1 % 4];
      cyc(($urandom % 60) == 0, 2'($urandom), mk(t0, 41'($urandom)), mk(t1, 41'($urandom)));
    end
    finish_run();
  end
endmodule